// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This controller collects requests from 28 sources and presents one interrupt to the processor. Sources 0 to 15 are internal and sources 16 to 27 are external. Sources 0 to 3 are serial channels. They sit in a priority table whose layout software chooses: either in four adjacent rows or in four rows spread through the table. Software also chooses which channel takes which row. Any single source can be promoted above all the others. The processor sees one request line at a programmable level. When the processor acknowledges, the controller returns a vector built from a programmable base and a per-source code. It also moves the winning source from pending to in-service. A new request interrupts only when it ranks strictly higher than every source already in service, so handlers nest properly.

Software reaches the controller through a small register port with four word addresses. Address 0 is configuration. Address 1 is the mask. Address 2 is pending, and writing 1 to a bit clears it. Address 3 is in-service, and writing 1 to a bit clears it.

Top module: `vec_intc`

## Requirements
- R1: After reset the configuration, mask, pending and in-service registers read as zero, and `ipl_o` is 0.
- R2: A high `req_i[n]` sets pending bit n at the next clock edge. Writing 1 to bit n at address 2 clears that bit.
- R3: `ipl_o` equals the configuration level (bits 2:0 at address 0) whenever an eligible source exists, and is 0 otherwise. A level of 0 therefore raises no request.
- R4: In the grouped scheme (bit 6 = 0), the four channel rows are ranks 4 to 7. The other sources fill the remaining ranks in ascending index order. Rank 0 is the highest.
- R5: In the spread scheme (bit 6 = 1), the channel rows are ranks 2, 9, 16 and 23.
- R6: The channel rotation (bits 8:7 = r) places channel (k + r) mod 4 in channel row k.
- R7: When bit 9 is 1, the source indexed by bits 14:10 outranks all others.
- R8: `vec_o` is {base (bits 5:3), code}. The code is the winner's index plus 1, or 0 (the error vector) when no source is eligible.
- R9: An acknowledge with an eligible winner clears the winner's pending bit and sets its in-service bit at the same clock edge.
- R10: A source is eligible only if it ranks strictly higher than every in-service source. Equal or lower sources wait.
- R11: Writing 1 to bit n at address 3 clears in-service bit n.
- R12: A source whose mask bit (address 1) is 1 is never eligible, but its pending bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 28 | Interrupt requests, one per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| iack_i | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| vec_o | output | 8 | Vector number for the current winner |
| ipl_o | output | 3 | Interrupt request level to the processor |

## Verification
Several properties are checked on every cycle. An acknowledged code always moves its source into service and clears its pending bit unless the source re-requests in the same cycle. A masked source never wins an acknowledge. A nonzero request level always equals the programmed level. No code above 28 is ever produced, and an active level with no request yields the error code. The scenarios are what show that the priority table is correct: the grouped and spread layouts, the rotation, promotion, and nesting decisions, each with known contending pairs and expected vectors.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_SRC = 28;
  localparam int NUM_SER = 4;
  localparam int SRC_W   = 5;
  localparam int KEY_W   = SRC_W + 1;
  localparam int VEC_W   = 8;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  typedef struct packed {
    logic [SRC_W-1:0] promo_idx;
    logic             promo_en;
    logic [1:0]       ser_rot;
    logic             spread;
    logic [2:0]       base;
    logic [2:0]       level;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 2'd0,
    A_MASK = 2'd1,
    A_PEND = 2'd2,
    A_INS  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      req_i,
  input  logic [N-1:0]      ack_oh_i,
  output cfg_t              cfg_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      pend_o,
  output logic [N-1:0]      ins_o
);
  logic [N-1:0] pend_clr, ins_clr;

  always_comb begin
    pend_clr = '0;
    ins_clr  = '0;
    if (wr_en_i && addr_i == A_PEND) pend_clr = wdata_i[N-1:0];
    if (wr_en_i && addr_i == A_INS)  ins_clr  = wdata_i[N-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      mask_o <= '0;
      pend_o <= '0;
      ins_o  <= '0;
    end else begin
      if (wr_en_i && addr_i == A_CFG)  cfg_o  <= cfg_t'(wdata_i[CFG_W-1:0]);
      if (wr_en_i && addr_i == A_MASK) mask_o <= wdata_i[N-1:0];
      // a fresh request wins over any clear in the same cycle
      pend_o <= (pend_o & ~pend_clr & ~ack_oh_i) | req_i;
      // a new acknowledge wins over a software clear
      ins_o  <= (ins_o & ~ins_clr) | ack_oh_i;
    end
  end
endmodule

// File: rtl/vic_rank.sv
module vic_rank
  import vic_pkg::*;
#(
  parameter int N        = NUM_SRC,
  parameter int NSER     = NUM_SER,
  parameter int GRP_BASE = 4,
  parameter int SPR_BASE = 2,
  parameter int SPR_STEP = 7
) (
  input  cfg_t                      cfg_i,
  output logic [N-1:0][KEY_W-1:0]   key_o
);
  function automatic int slot_rank(input int k, input logic spread);
    return spread ? (SPR_BASE + k * SPR_STEP) : (GRP_BASE + k);
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_src
    logic promo_hit;
    int   rank;
    assign promo_hit = cfg_i.promo_en && (int'(cfg_i.promo_idx) == i);

    if (i < NSER) begin : g_ser
      always_comb begin
        int k;
        k    = (i + NSER - int'(cfg_i.ser_rot)) % NSER;
        rank = slot_rank(k, cfg_i.spread);
      end
    end else begin : g_fix
      always_comb begin
        int r;
        r = i - NSER;
        // channel rows are ascending, so one pass shifts past each in turn
        for (int s = 0; s < NSER; s++)
          if (r >= slot_rank(s, cfg_i.spread)) r = r + 1;
        rank = r;
      end
    end

    assign key_o[i] = {~promo_hit, SRC_W'(rank)};
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0][KEY_W-1:0] key_i,
  input  logic [N-1:0]            pend_i,
  input  logic [N-1:0]            mask_i,
  input  logic [N-1:0]            ins_i,
  output logic                    win_vld_o,
  output logic [SRC_W-1:0]        win_idx_o
);
  logic [KEY_W-1:0] floor_key, best_key;

  // rank of the highest in-service source, all ones when none
  always_comb begin
    floor_key = '1;
    for (int i = 0; i < N; i++)
      if (ins_i[i] && key_i[i] < floor_key) floor_key = key_i[i];
  end

  always_comb begin
    best_key  = '1;
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i] && !mask_i[i] && key_i[i] < floor_key && key_i[i] < best_key) begin
        best_key  = key_i[i];
        win_vld_o = 1'b1;
        win_idx_o = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int N        = NUM_SRC,
  parameter int NSER     = NUM_SER,
  parameter int GRP_BASE = 4,
  parameter int SPR_BASE = 2,
  parameter int SPR_STEP = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              iack_i,
  output logic [VEC_W-1:0]  vec_o,
  output logic [2:0]        ipl_o
);
  cfg_t                    cfg_w;
  logic [N-1:0]            mask_w, pend_w, ins_w, ack_oh;
  logic [N-1:0][KEY_W-1:0] key_w;
  logic                    win_vld;
  logic [SRC_W-1:0]        win_idx;
  logic [SRC_W-1:0]        code;

  assign ack_oh = (iack_i && win_vld) ? (N'(1) << win_idx) : '0;

  vic_regs #(.N(N)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .req_i   (req_i),
    .ack_oh_i(ack_oh),
    .cfg_o   (cfg_w),
    .mask_o  (mask_w),
    .pend_o  (pend_w),
    .ins_o   (ins_w)
  );

  vic_rank #(
    .N(N), .NSER(NSER), .GRP_BASE(GRP_BASE), .SPR_BASE(SPR_BASE), .SPR_STEP(SPR_STEP)
  ) u_rank (
    .cfg_i(cfg_w),
    .key_o(key_w)
  );

  vic_arb #(.N(N)) u_arb (
    .key_i    (key_w),
    .pend_i   (pend_w),
    .mask_i   (mask_w),
    .ins_i    (ins_w),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx)
  );

  assign code  = win_vld ? (win_idx + SRC_W'(1)) : '0;
  assign vec_o = {cfg_w.base, code};
  assign ipl_o = win_vld ? cfg_w.level : 3'd0;

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      A_CFG:   rdata_o = DATA_W'(cfg_w);
      A_MASK:  rdata_o = DATA_W'(mask_w);
      A_PEND:  rdata_o = DATA_W'(pend_w);
      default: rdata_o = DATA_W'(ins_w);
    endcase
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
  import vic_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iack_i,
  input logic [VEC_W-1:0] vec_i,
  input logic [2:0]       ipl_i,
  input logic [2:0]       level_i,
  input logic [N-1:0]     req_i,
  input logic [N-1:0]     pend_i,
  input logic [N-1:0]     mask_i,
  input logic [N-1:0]     ins_i
);
  logic [31:0]      pend_p, mask_p, ins_p, req_l;
  logic [SRC_W-1:0] code, code_l;

  assign pend_p = 32'(pend_i);
  assign mask_p = 32'(mask_i);
  assign ins_p  = 32'(ins_i);
  assign code   = vec_i[SRC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_l <= '0;
      req_l  <= '0;
    end else begin
      code_l <= code;
      req_l  <= 32'(req_i);
    end
  end

  assert_ack_sets_ins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && code != '0) |=> ins_p[code_l - SRC_W'(1)]);

  assert_ack_clears_pend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && code != '0) |=> (!pend_p[code_l - SRC_W'(1)] || req_l[code_l - SRC_W'(1)]));

  assert_masked_never_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && code != '0) |-> !mask_p[code - SRC_W'(1)]);

  assert_level_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipl_i != 3'd0) |-> (ipl_i == level_i));

  assert_error_vector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && ipl_i == 3'd0 && level_i != 3'd0) |-> (code == '0));

  assert_code_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(code) <= N);
endmodule

bind vec_intc vec_intc_chk #(.N(N)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .iack_i (iack_i),
  .vec_i  (vec_o),
  .ipl_i  (ipl_o),
  .level_i(cfg_w.level),
  .req_i  (req_i),
  .pend_i (pend_w),
  .mask_i (mask_w),
  .ins_i  (ins_w)
);

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
  localparam int N = 28;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        iack_i = 1'b0;
  logic [7:0]  vec_o;
  logic [2:0]  ipl_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk_i = ~clk_i;

  vec_intc dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .iack_i(iack_i),
    .vec_o(vec_o), .ipl_o(ipl_o)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  // monitor: compares each acknowledge vector with the scoreboard head
  initial forever begin
    @(negedge clk_i);
    #5;
    if (iack_i) begin
      if (exp_q.size() == 0) check(32'(vec_o), 32'hFFFF, "ack with empty scoreboard");
      else check(32'(vec_o), 32'(exp_q.pop_front()), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    addr_i = a;
    #5 check(rdata_o, exp, tag);
    @(negedge clk_i);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    req_i = m;
    @(negedge clk_i);
    req_i = '0;
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    iack_i = 1'b1;
    @(negedge clk_i);
    iack_i = 1'b0;
  endtask

  task automatic chk_ipl(input logic [2:0] exp, input string tag);
    #5 check(32'(ipl_o), 32'(exp), tag);
    @(negedge clk_i);
  endtask

  localparam logic [31:0] CFG  = 32'h1D;  // level 5, base 3, grouped, rot 0
  localparam logic [31:0] ALL  = 32'h0FFF_FFFF;

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk_ipl(3'd0, "R1 ipl");
    rd(2'd0, 32'h0, "R1 cfg");
    rd(2'd1, 32'h0, "R1 mask");
    rd(2'd2, 32'h0, "R1 pend");
    rd(2'd3, 32'h0, "R1 ins");

    // R2/R3 level 0 holds off the request
    pulse(N'(1) << 10);
    rd(2'd2, 32'h400, "R2 pending set");
    chk_ipl(3'd0, "R3 level 0 no request");
    wr(2'd0, CFG);
    chk_ipl(3'd5, "R3 level 5");
    wr(2'd2, 32'h400);
    rd(2'd2, 32'h0, "R2 pending cleared");
    chk_ipl(3'd0, "R3 nothing eligible");
    ack(8'h60, "R8 error vector");

    // R4 grouped: idx5 rank1, ch2 rank6, idx9 rank9
    pulse((N'(1) << 5) | (N'(1) << 2) | (N'(1) << 9));
    ack(8'h66, "R4 grouped winner idx5");
    rd(2'd3, 32'h20, "R9 in-service set");
    rd(2'd2, 32'h204, "R9 pending cleared");
    chk_ipl(3'd0, "R10 lower waits");
    ack(8'h60, "R10 error while blocked");
    wr(2'd3, 32'h20);
    rd(2'd3, 32'h0, "R11 in-service cleared");
    ack(8'h63, "R4 channel 2 rank6");
    chk_ipl(3'd0, "R10 idx9 below ch2");
    pulse(N'(1) << 4);
    chk_ipl(3'd5, "R10 higher nests");
    ack(8'h65, "R10 nested idx4");
    wr(2'd3, ALL);
    ack(8'h6A, "R4 idx9 last");
    wr(2'd3, ALL);

    // R5 spread: ch0 rank2 beats idx6 rank3
    wr(2'd0, CFG | 32'h40);
    pulse((N'(1) << 6) | (N'(1) << 0));
    ack(8'h61, "R5 spread ch0 first");
    wr(2'd3, ALL);
    ack(8'h67, "R5 spread idx6 next");
    wr(2'd3, ALL);

    // R6 rotation 1: ch3 in row 2, ch0 in row 3
    wr(2'd0, CFG | 32'h80);
    pulse((N'(1) << 0) | (N'(1) << 3));
    ack(8'h64, "R6 rotated ch3 first");
    wr(2'd3, ALL);
    ack(8'h61, "R6 rotated ch0 next");
    wr(2'd3, ALL);

    // R7 promote idx27
    wr(2'd0, CFG | 32'h200 | (32'd27 << 10));
    pulse((N'(1) << 4) | (N'(1) << 27));
    ack(8'h7C, "R7 promoted idx27");
    chk_ipl(3'd0, "R7 promoted blocks all");
    wr(2'd3, ALL);
    ack(8'h65, "R7 idx4 after");
    wr(2'd3, ALL);

    // R12 mask
    wr(2'd0, CFG);
    wr(2'd1, 32'h10);
    rd(2'd1, 32'h10, "R12 mask readback");
    pulse((N'(1) << 4) | (N'(1) << 20));
    ack(8'h75, "R12 masked skipped");
    wr(2'd3, ALL);
    chk_ipl(3'd0, "R12 masked not eligible");
    rd(2'd2, 32'h10, "R12 pending kept");
    wr(2'd1, 32'h0);
    chk_ipl(3'd5, "R12 unmasked eligible");
    ack(8'h65, "R12 unmasked wins");
    wr(2'd3, ALL);

    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "scoreboard drained");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule